// File: doc/BRIEF.md
# Runtime-Programmable Sum-of-Products Array

This block is a small logic array whose AND plane and OR plane are both set at run time. Each input reaches the AND plane in true and in inverted form. Every product term chooses, for each input, the true literal, the inverted literal or no connection. A fourth code pins the term to zero. Each output ORs a chosen subset of the product terms and then passes or inverts that sum under its own polarity bit. Only the programmed terms exist, so the array does not decode the full set of minterms.

Configuration arrives one word at a time over a valid/ready write port. A two-state load machine handles it. In IDLE, `cfg_ready` is high. A word offered with `cfg_valid` is captured (transition ACCEPT) and the machine moves to COMMIT. In COMMIT, `cfg_ready` is low and the captured word is written into the plane it selects. The machine then returns to IDLE unconditionally (transition RETIRE). The outputs are computed combinationally from `pla_in` and the stored planes, with no register on the evaluation path.

A word for the AND plane (`cfg_target`=0) carries a whole term row: `cfg_index` selects the term, and input i uses `cfg_data[2i+1:2i]`. A word for the OR plane (`cfg_target`=1) carries a whole output setting: `cfg_index` selects the output, `cfg_data[NUM_TERMS-1:0]` is the term mask with bit t for term t, and `cfg_data[NUM_TERMS]` is the polarity.

Top module: `prog_logic_array`

## Requirements
- R1: After reset, `cfg_ready` is 1, every term cell holds 00, every OR mask is 0 and every polarity is 0, so all outputs read 0 for every input value.
- R2: In an AND-plane cell, code 01 connects the true literal of that input (the term needs the input at 1) and code 10 connects the inverted literal (the term needs the input at 0).
- R3: A cell holding code 11 forces its product term to 0, whatever the inputs are.
- R4: A product term whose cells all hold 00 (no connection) evaluates to 1.
- R5: Output o is the OR of every term t whose mask bit `cfg_data[t]` was written as 1 for that output. An all-zero mask gives an OR result of 0.
- R6: A polarity bit of 1 (`cfg_data[NUM_TERMS]`) inverts the output's OR result. A polarity bit of 0 passes the result through.
- R7: A word is accepted on a rising edge where `cfg_valid` and `cfg_ready` are both 1. `cfg_ready` is 0 for the next cycle. The stored planes change only at the end of that cycle, so outputs show the new setting after the second edge and not after the first.
- R8: An OR-plane write whose `cfg_index` is NUM_OUT or higher changes no output and no stored setting.
- R9: Outputs follow a change on `pla_in` within the same clock cycle, with no clock edge needed.
- R10: When the array is loaded with terms AB', AC, BC and A'BC' (A=`pla_in[2]`, B=`pla_in[1]`, C=`pla_in[0]`), output 0 set to terms {0,1,3} with polarity 0 and output 1 set to terms {1,2} with polarity 1 produce F1=AB'+AC+A'BC' and F2=(AC+BC)' for all 8 input values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration storage and the load machine |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | A configuration word is offered |
| cfg_ready | output | 1 | High in IDLE, when a word can be accepted |
| cfg_target | input | 1 | 0 selects the AND plane, 1 selects the OR plane |
| cfg_index | input | IDX_W (2) | Term index (AND plane) or output index (OR plane) |
| cfg_data | input | DATA_W (6) | Term cells or output mask and polarity |
| pla_in | input | NUM_IN (3) | Logic inputs |
| pla_out | output | NUM_OUT (2) | Logic outputs |

## Verification
A wrong stored cell or mask bit shows on `pla_out` at once. It appears only for the input values where the affected term decides the output, so every configuration is checked against all 8 input values rather than a few. A load machine stuck in COMMIT, or one that returns too early, shows on `cfg_ready` in the cycle after acceptance. A commit that lands one edge early or late shows on the outputs sampled between the two edges. A write to an out-of-range index that corrupts a real output shows on the next full input sweep.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;

    // Two-bit code held for each (term, input) crossing of the AND plane
    typedef enum logic [1:0] {
        CELL_DC   = 2'b00,
        CELL_TRUE = 2'b01,
        CELL_COMP = 2'b10,
        CELL_ZERO = 2'b11
    } cell_e;

    // States of the configuration load machine
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } load_state_e;

    // Plane selected by a configuration word
    typedef enum logic {
        TGT_AND = 1'b0,
        TGT_OR  = 1'b1
    } target_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned idx_bits(input int unsigned count);
        return ($clog2(count) < 1) ? 1 : $clog2(count);
    endfunction

endpackage

// File: rtl/pla_load_fsm.sv
`timescale 1ns/1ps
module pla_load_fsm
    import pla_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int DATA_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              cfg_target,
    input  logic [IDX_W-1:0]  cfg_index,
    input  logic [DATA_W-1:0] cfg_data,
    output logic              cfg_ready,
    output logic              commit_en,
    output logic              commit_target,
    output logic [IDX_W-1:0]  commit_index,
    output logic [DATA_W-1:0] commit_data
);

    load_state_e state_q;
    load_state_e state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Transitions: ACCEPT (IDLE -> COMMIT), RETIRE (COMMIT -> IDLE)
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (cfg_valid) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
        endcase
    end

    // Capture of the offered word on ACCEPT
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_target <= 1'b0;
            commit_index  <= '0;
            commit_data   <= '0;
        end else if (state_q == ST_IDLE && cfg_valid) begin
            commit_target <= cfg_target;
            commit_index  <= cfg_index;
            commit_data   <= cfg_data;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        cfg_ready = 1'b0;
        commit_en = 1'b0;
        unique case (state_q)
            ST_IDLE:   cfg_ready = 1'b1;
            ST_COMMIT: commit_en = 1'b1;
        endcase
    end

endmodule

// File: rtl/pla_and_plane.sv
`timescale 1ns/1ps
module pla_and_plane
    import pla_pkg::*;
#(
    parameter int NUM_IN    = 3,
    parameter int NUM_TERMS = 4,
    parameter int IDX_W     = 2,
    localparam int ROW_W    = 2 * NUM_IN
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit_en,
    input  logic                       commit_target,
    input  logic [IDX_W-1:0]           commit_index,
    input  logic [ROW_W-1:0]           commit_row,
    input  logic [NUM_IN-1:0]          pla_in,
    output logic [NUM_TERMS*ROW_W-1:0] and_cfg_flat,
    output logic [NUM_TERMS-1:0]       term_vec
);

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
        logic [ROW_W-1:0] row_q;
        logic             term_hit;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q <= '0;
            end else if (commit_en && commit_target == TGT_AND &&
                         commit_index == IDX_W'(t)) begin
                row_q <= commit_row;
            end
        end

        always_comb begin
            term_hit = 1'b1;
            for (int i = 0; i < NUM_IN; i++) begin
                unique case (cell_e'(row_q[2*i +: 2]))
                    CELL_DC:   term_hit = term_hit;
                    CELL_TRUE: term_hit = term_hit & pla_in[i];
                    CELL_COMP: term_hit = term_hit & ~pla_in[i];
                    CELL_ZERO: term_hit = 1'b0;
                endcase
            end
        end

        assign and_cfg_flat[t*ROW_W +: ROW_W] = row_q;
        assign term_vec[t] = term_hit;
    end

endmodule

// File: rtl/pla_or_plane.sv
`timescale 1ns/1ps
module pla_or_plane
    import pla_pkg::*;
#(
    parameter int NUM_TERMS = 4,
    parameter int NUM_OUT   = 2,
    parameter int IDX_W     = 2,
    localparam int SET_W    = NUM_TERMS + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit_en,
    input  logic                         commit_target,
    input  logic [IDX_W-1:0]             commit_index,
    input  logic [SET_W-1:0]             commit_set,
    input  logic [NUM_TERMS-1:0]         term_vec,
    output logic [NUM_OUT*NUM_TERMS-1:0] or_mask_flat,
    output logic [NUM_OUT-1:0]           or_pol,
    output logic [NUM_OUT-1:0]           pla_out
);

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        logic [NUM_TERMS-1:0] mask_q;
        logic                 pol_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q <= '0;
                pol_q  <= 1'b0;
            end else if (commit_en && commit_target == TGT_OR &&
                         commit_index == IDX_W'(o)) begin
                mask_q <= commit_set[NUM_TERMS-1:0];
                pol_q  <= commit_set[NUM_TERMS];
            end
        end

        assign or_mask_flat[o*NUM_TERMS +: NUM_TERMS] = mask_q;
        assign or_pol[o]  = pol_q;
        assign pla_out[o] = (|(term_vec & mask_q)) ^ pol_q;
    end

endmodule

// File: rtl/prog_logic_array.sv
`timescale 1ns/1ps
module prog_logic_array
    import pla_pkg::*;
#(
    parameter int NUM_IN    = 3,
    parameter int NUM_TERMS = 4,
    parameter int NUM_OUT   = 2,
    localparam int IDX_W    = idx_bits(max2(NUM_TERMS, NUM_OUT)),
    localparam int ROW_W    = 2 * NUM_IN,
    localparam int SET_W    = NUM_TERMS + 1,
    localparam int DATA_W   = max2(ROW_W, SET_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    output logic              cfg_ready,
    input  logic              cfg_target,
    input  logic [IDX_W-1:0]  cfg_index,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic [NUM_IN-1:0] pla_in,
    output logic [NUM_OUT-1:0] pla_out
);

    logic                         commit_en;
    logic                         commit_target;
    logic [IDX_W-1:0]             commit_index;
    logic [DATA_W-1:0]            commit_data;
    logic [NUM_TERMS*ROW_W-1:0]   and_cfg_flat;
    logic [NUM_TERMS-1:0]         term_vec;
    logic [NUM_OUT*NUM_TERMS-1:0] or_mask_flat;
    logic [NUM_OUT-1:0]           or_pol;

    pla_load_fsm #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_load (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_valid     (cfg_valid),
        .cfg_target    (cfg_target),
        .cfg_index     (cfg_index),
        .cfg_data      (cfg_data),
        .cfg_ready     (cfg_ready),
        .commit_en     (commit_en),
        .commit_target (commit_target),
        .commit_index  (commit_index),
        .commit_data   (commit_data)
    );

    pla_and_plane #(
        .NUM_IN    (NUM_IN),
        .NUM_TERMS (NUM_TERMS),
        .IDX_W     (IDX_W)
    ) u_and (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_en     (commit_en),
        .commit_target (commit_target),
        .commit_index  (commit_index),
        .commit_row    (commit_data[ROW_W-1:0]),
        .pla_in        (pla_in),
        .and_cfg_flat  (and_cfg_flat),
        .term_vec      (term_vec)
    );

    pla_or_plane #(
        .NUM_TERMS (NUM_TERMS),
        .NUM_OUT   (NUM_OUT),
        .IDX_W     (IDX_W)
    ) u_or (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_en     (commit_en),
        .commit_target (commit_target),
        .commit_index  (commit_index),
        .commit_set    (commit_data[SET_W-1:0]),
        .term_vec      (term_vec),
        .or_mask_flat  (or_mask_flat),
        .or_pol        (or_pol),
        .pla_out       (pla_out)
    );

endmodule

// File: rtl/pla_checker.sv
`timescale 1ns/1ps
module pla_checker #(
    parameter int NUM_IN    = 3,
    parameter int NUM_TERMS = 4,
    parameter int NUM_OUT   = 2,
    parameter int IDX_W     = 2,
    localparam int ROW_W    = 2 * NUM_IN
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cfg_valid,
    input logic                         cfg_ready,
    input logic                         commit_en,
    input logic                         commit_target,
    input logic [IDX_W-1:0]             commit_index,
    input logic [NUM_TERMS*ROW_W-1:0]   and_cfg_flat,
    input logic [NUM_TERMS-1:0]         term_vec,
    input logic [NUM_OUT*NUM_TERMS-1:0] or_mask_flat,
    input logic [NUM_OUT-1:0]           or_pol,
    input logic [NUM_OUT-1:0]           pla_out
);

    assert_ready_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_ready) |=> !cfg_ready);

    assert_ready_returns_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ready |=> cfg_ready);

    assert_and_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_en |=> $stable(and_cfg_flat));

    assert_or_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_en |=> ($stable(or_mask_flat) && $stable(or_pol)));

    assert_bad_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && commit_target && int'(commit_index) >= NUM_OUT)
        |=> ($stable(or_mask_flat) && $stable(or_pol)));

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term_chk
        logic [ROW_W-1:0] row;
        logic             any_zero;
        assign row = and_cfg_flat[t*ROW_W +: ROW_W];
        always_comb begin
            any_zero = 1'b0;
            for (int i = 0; i < NUM_IN; i++) begin
                if (row[2*i +: 2] == 2'b11) any_zero = 1'b1;
            end
        end

        assert_zero_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
            any_zero |-> !term_vec[t]);

        assert_blank_term_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (row == '0) |-> term_vec[t]);
    end

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out_chk
        assert_empty_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (or_mask_flat[o*NUM_TERMS +: NUM_TERMS] == '0) |-> (pla_out[o] == or_pol[o]));
    end

endmodule

bind prog_logic_array pla_checker #(
    .NUM_IN    (NUM_IN),
    .NUM_TERMS (NUM_TERMS),
    .NUM_OUT   (NUM_OUT),
    .IDX_W     (IDX_W)
) u_pla_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_valid     (cfg_valid),
    .cfg_ready     (cfg_ready),
    .commit_en     (commit_en),
    .commit_target (commit_target),
    .commit_index  (commit_index),
    .and_cfg_flat  (and_cfg_flat),
    .term_vec      (term_vec),
    .or_mask_flat  (or_mask_flat),
    .or_pol        (or_pol),
    .pla_out       (pla_out)
);

// File: tb/tb_prog_logic_array.sv
`timescale 1ns/1ps
module tb_prog_logic_array;

    localparam int NI = 3;
    localparam int NT = 4;
    localparam int NO = 2;
    localparam int IW = 2;
    localparam int DW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_valid = 1'b0;
    logic          cfg_ready;
    logic          cfg_target = 1'b0;
    logic [IW-1:0] cfg_index = '0;
    logic [DW-1:0] cfg_data = '0;
    logic [NI-1:0] pla_in = '0;
    logic [NO-1:0] pla_out;

    int n_checks = 0;
    int n_fail   = 0;

    // Bench-side model of the stored configuration
    logic [DW-1:0] m_row  [NT];
    logic [NT-1:0] m_mask [NO];
    logic          m_pol  [NO];

    always #2.5 clk = ~clk;

    prog_logic_array dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_valid  (cfg_valid),
        .cfg_ready  (cfg_ready),
        .cfg_target (cfg_target),
        .cfg_index  (cfg_index),
        .cfg_data   (cfg_data),
        .pla_in     (pla_in),
        .pla_out    (pla_out)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NO-1:0] model(input logic [NI-1:0] x);
        logic [NT-1:0] tv;
        logic [NO-1:0] r;
        for (int t = 0; t < NT; t++) begin
            tv[t] = 1'b1;
            for (int i = 0; i < NI; i++) begin
                case (m_row[t][2*i +: 2])
                    2'b01:   tv[t] = tv[t] & x[i];
                    2'b10:   tv[t] = tv[t] & ~x[i];
                    2'b11:   tv[t] = 1'b0;
                    default: tv[t] = tv[t];
                endcase
            end
        end
        for (int o = 0; o < NO; o++) r[o] = (|(tv & m_mask[o])) ^ m_pol[o];
        return r;
    endfunction

    task automatic cfg_write(input logic tgt, input int idx, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_valid  = 1'b1;
        cfg_target = tgt;
        cfg_index  = IW'(idx);
        cfg_data   = d;
        @(negedge clk);
        cfg_valid  = 1'b0;
        @(negedge clk);
        if (!tgt && idx < NT) m_row[idx] = d;
        if (tgt && idx < NO) begin
            m_mask[idx] = d[NT-1:0];
            m_pol[idx]  = d[NT];
        end
    endtask

    task automatic sweep(input string req);
        for (int v = 0; v < (1 << NI); v++) begin
            pla_in = NI'(v);
            #0.5;
            check(req, 32'(pla_out), 32'(model(pla_in)), $sformatf("in=%0d", v));
        end
    endtask

    initial begin
        for (int t = 0; t < NT; t++) m_row[t] = '0;
        for (int o = 0; o < NO; o++) begin
            m_mask[o] = '0;
            m_pol[o]  = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1", 32'(cfg_ready), 32'd1, "ready after reset");
        sweep("R1");

        // R7: timing of acceptance and commit (output 0 <- term 0, polarity 0)
        @(negedge clk);
        cfg_valid  = 1'b1;
        cfg_target = 1'b1;
        cfg_index  = 2'd0;
        cfg_data   = 6'b00_0001;
        pla_in     = 3'd5;
        @(negedge clk);
        cfg_valid  = 1'b0;
        check("R7", 32'(cfg_ready), 32'd0, "ready low in commit cycle");
        check("R7", 32'(pla_out), 32'd0, "output unchanged before commit");
        @(negedge clk);
        m_mask[0] = 4'b0001;
        check("R7", 32'(cfg_ready), 32'd1, "ready back after commit");
        check("R7", 32'(pla_out[0]), 32'd1, "output updated after commit");

        // R4: term 0 with every cell disconnected drives output 0 high
        sweep("R4");

        // R2: true and inverted literal on each input
        for (int i = 0; i < NI; i++) begin
            cfg_write(1'b0, 0, DW'(2'b01) << (2 * i));
            sweep("R2");
            cfg_write(1'b0, 0, DW'(2'b10) << (2 * i));
            sweep("R2");
        end

        // R3: zero code forces the term off
        cfg_write(1'b0, 0, 6'b00_11_00);
        sweep("R3");
        cfg_write(1'b0, 0, 6'b01_01_11);
        sweep("R3");

        // R6: inverted polarity on a term that is forced off
        cfg_write(1'b1, 0, 6'b01_0001);
        sweep("R6");
        check("R6", 32'(pla_out[0]), 32'd1, "inverted empty sum");

        // R8: writes to nonexistent outputs change nothing
        cfg_write(1'b1, 2, 6'b01_1111);
        sweep("R8");
        cfg_write(1'b1, 3, 6'b01_1111);
        sweep("R8");

        // R10: example functions, checked against the formulas
        cfg_write(1'b0, 0, 6'b01_10_00);
        cfg_write(1'b0, 1, 6'b01_00_01);
        cfg_write(1'b0, 2, 6'b00_01_01);
        cfg_write(1'b0, 3, 6'b10_01_10);
        cfg_write(1'b1, 0, 6'b00_1011);
        cfg_write(1'b1, 1, 6'b01_0110);
        for (int v = 0; v < 8; v++) begin
            logic a, b, c, f1, f2;
            a  = v[2];
            b  = v[1];
            c  = v[0];
            f1 = (a & ~b) | (a & c) | (~a & b & ~c);
            f2 = ~((a & c) | (b & c));
            pla_in = 3'(v);
            #0.5;
            check("R10", 32'(pla_out), 32'({f2, f1}), $sformatf("in=%0d", v));
        end

        // R9: output follows input inside one low clock phase
        @(negedge clk);
        pla_in = 3'b100;
        #0.5;
        check("R9", 32'(pla_out[0]), 32'd1, "A=1 B=0 C=0");
        pla_in = 3'b000;
        #0.5;
        check("R9", 32'(pla_out[0]), 32'd0, "A=0 B=0 C=0");

        // R5: every mask on output 1 with polarity 0
        for (int m = 0; m < 16; m++) begin
            cfg_write(1'b1, 1, DW'(m));
            sweep("R5");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule